// File: doc/BRIEF.md
# Dual-Copy Check-Bit Hamming Codec

This block protects one memory word against single and double bit upsets. On the write side it computes one set of extended Hamming check bits (single-error-correct, double-error-detect) for the data word and presents two identical copies of them. Both copies are stored next to the data. Nothing is extended beyond one parity bit per copy: the redundancy comes from duplication.

On the read side the stored data word is decoded twice, in parallel. Path A pairs the data with copy A and path B pairs it with copy B. Each path corrects a single flip and raises its own double-error flag. Path A's result is used when its flag is clear. If A flags a double error, path B's result is used when B's flag is clear. If both paths flag, the word is reported as uncorrectable. As a result, any one or two flipped bits are corrected, except two flips that both fall in the data field. The codec is purely combinational and is meant to sit between a memory array and its users.

Top module: `dmr_ham_codec`

## Requirements
- R1: Each check-bit copy has width H+1. H is the smallest value with 2^H >= DATA_W+H+1. Codeword positions 1..DATA_W+H place Hamming bit j at position 2^j, and data bits 0 upward fill the remaining positions in ascending order. Hamming bit j (copy bit j) is the XOR of the data bits whose position has bit j set. Copy bit H is the even parity over the data and the H Hamming bits. wr_chk_a_o and wr_chk_b_o are always equal.
- R2: With no bit flipped, rd_data_o equals the stored data and both error outputs are 0.
- R3: A single flip anywhere (data, copy A or copy B) returns the original data with err_uncorr_o low.
- R4: One flip in a data bit together with one flip in copy A returns the original data. The data is taken from path B.
- R5: Exactly one flip in each of the two copies returns the data unchanged.
- R6: Two flips inside the same copy, or one data flip plus one flip in copy B, return the original data.
- R7: err_uncorr_o is 1 exactly when both paths report a double error, for example one flip in data plus one flip in each copy. It is 0 for every pattern of R2 to R6.
- R8: err_single_o is 1 when the selected path, A unless A reports a double error, sees a nonzero syndrome or a parity mismatch. It is 0 whenever err_uncorr_o is 1.
- R9: DATA_W values 4, 8 and 11 are supported, giving copy widths 4, 5 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_data_i | input | DATA_W | Data word to encode |
| wr_chk_a_o | output | CHK_W | Check-bit copy A for storage |
| wr_chk_b_o | output | CHK_W | Check-bit copy B for storage |
| rd_data_i | input | DATA_W | Data word read from storage |
| rd_chk_a_i | input | CHK_W | Copy A read from storage |
| rd_chk_b_i | input | CHK_W | Copy B read from storage |
| rd_data_o | output | DATA_W | Corrected data |
| err_single_o | output | 1 | Selected path saw an error |
| err_uncorr_o | output | 1 | Both paths report a double error |

## Verification
The case of interest is a read in which path A's correction and path B's correction disagree. Path A flags a double error while path B quietly fixes a single data flip, so the fallback selection and the single-error report both depend on the same word. This is provoked by walking every pair of flipped positions across data and both copies, for many data patterns at each supported width, skipping only pairs inside the data field. The data output and both flags are judged against flip counts that the bench computes for each path. Triple flips that span data and both copies provoke the uncorrectable outcome.

// File: rtl/dmr_ham_pkg.sv
package dmr_ham_pkg;

  // number of Hamming bits for a given data width
  function automatic int ham_bits(input int dw);
    for (int r = 1; r < 8; r++)
      if ((1 << r) >= dw + r + 1) return r;
    return 8;
  endfunction

  // codeword position of data bit idx (skips power-of-two slots)
  function automatic int data_pos(input int idx);
    int cnt;
    cnt = -1;
    for (int p = 1; p < 64; p++) begin
      if ((p & (p - 1)) != 0) begin
        cnt++;
        if (cnt == idx) return p;
      end
    end
    return 0;
  endfunction

endpackage

// File: rtl/dmr_ham_gen.sv
module dmr_ham_gen import dmr_ham_pkg::*; #(
  parameter int DATA_W = 8,
  localparam int HAM_W = ham_bits(DATA_W)
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [HAM_W-1:0]  ham_o
);

  // flat XOR trees, one per check bit
  always_comb begin
    ham_o = '0;
    for (int i = 0; i < DATA_W; i++)
      for (int j = 0; j < HAM_W; j++)
        if (((data_pos(i) >> j) & 1) != 0) ham_o[j] = ham_o[j] ^ data_i[i];
  end

endmodule

// File: rtl/dmr_ham_path.sv
module dmr_ham_path import dmr_ham_pkg::*; #(
  parameter int DATA_W = 8,
  localparam int HAM_W  = ham_bits(DATA_W),
  localparam int CHK_W  = HAM_W + 1,
  localparam int CODE_W = DATA_W + HAM_W
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [CHK_W-1:0]  chk_i,
  output logic [DATA_W-1:0] data_o,
  output logic              dbl_o,
  output logic              any_o
);

  logic [HAM_W-1:0] ham_calc;
  logic [HAM_W-1:0] syn;
  logic             par_odd;

  dmr_ham_gen #(.DATA_W(DATA_W)) u_gen (
    .data_i (data_i),
    .ham_o  (ham_calc)
  );

  always_comb begin
    syn     = ham_calc ^ chk_i[HAM_W-1:0];
    par_odd = ^{data_i, chk_i};
    data_o  = data_i;
    for (int i = 0; i < DATA_W; i++)
      if (par_odd && (syn == HAM_W'(data_pos(i)))) data_o[i] = ~data_i[i];
    any_o = par_odd | (|syn);
    // even parity with a syndrome, or odd parity pointing past the codeword
    dbl_o = (!par_odd && (|syn)) || (par_odd && (int'(syn) > CODE_W));
  end

  always_comb begin
    p_one_fix_r3: assert ($countones(data_o ^ data_i) <= 1)
      else $error("path changed more than one data bit");
    if (dbl_o) begin
      p_dbl_no_fix_r7: assert (data_o == data_i)
        else $error("path corrected while flagging double");
    end
  end

endmodule

// File: rtl/dmr_ham_sel.sv
module dmr_ham_sel #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data_a_i,
  input  logic              dbl_a_i,
  input  logic              any_a_i,
  input  logic [DATA_W-1:0] data_b_i,
  input  logic              dbl_b_i,
  input  logic              any_b_i,
  output logic [DATA_W-1:0] data_o,
  output logic              single_o,
  output logic              uncorr_o
);

  always_comb begin
    if (!dbl_a_i) begin
      data_o   = data_a_i;
      single_o = any_a_i;
      uncorr_o = 1'b0;
    end else if (!dbl_b_i) begin
      data_o   = data_b_i;
      single_o = any_b_i;
      uncorr_o = 1'b0;
    end else begin
      data_o   = data_a_i;
      single_o = 1'b0;
      uncorr_o = 1'b1;
    end
  end

endmodule

// File: rtl/dmr_ham_codec.sv
module dmr_ham_codec import dmr_ham_pkg::*; #(
  parameter int DATA_W = 8,
  localparam int HAM_W = ham_bits(DATA_W),
  localparam int CHK_W = HAM_W + 1
) (
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [CHK_W-1:0]  wr_chk_a_o,
  output logic [CHK_W-1:0]  wr_chk_b_o,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic [CHK_W-1:0]  rd_chk_a_i,
  input  logic [CHK_W-1:0]  rd_chk_b_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              err_single_o,
  output logic              err_uncorr_o
);

  logic [HAM_W-1:0]  wr_ham;
  logic [CHK_W-1:0]  wr_chk;
  logic [DATA_W-1:0] data_a, data_b;
  logic              dbl_a, dbl_b, any_a, any_b;

  dmr_ham_gen #(.DATA_W(DATA_W)) u_enc (
    .data_i (wr_data_i),
    .ham_o  (wr_ham)
  );

  assign wr_chk     = {^{wr_data_i, wr_ham}, wr_ham};
  assign wr_chk_a_o = wr_chk;
  assign wr_chk_b_o = wr_chk;

  dmr_ham_path #(.DATA_W(DATA_W)) u_path_a (
    .data_i (rd_data_i),
    .chk_i  (rd_chk_a_i),
    .data_o (data_a),
    .dbl_o  (dbl_a),
    .any_o  (any_a)
  );

  dmr_ham_path #(.DATA_W(DATA_W)) u_path_b (
    .data_i (rd_data_i),
    .chk_i  (rd_chk_b_i),
    .data_o (data_b),
    .dbl_o  (dbl_b),
    .any_o  (any_b)
  );

  dmr_ham_sel #(.DATA_W(DATA_W)) u_sel (
    .data_a_i (data_a),
    .dbl_a_i  (dbl_a),
    .any_a_i  (any_a),
    .data_b_i (data_b),
    .dbl_b_i  (dbl_b),
    .any_b_i  (any_b),
    .data_o   (rd_data_o),
    .single_o (err_single_o),
    .uncorr_o (err_uncorr_o)
  );

  always_comb begin
    if (!dbl_a) begin
      p_sel_a_r7: assert (rd_data_o == data_a)
        else $error("path A clean but not selected");
    end
    if (dbl_a && !dbl_b) begin
      p_sel_b_r4: assert ((rd_data_o == data_b) && (err_single_o == any_b))
        else $error("fallback to path B not taken");
    end
    p_uncorr_r7: assert (err_uncorr_o == (dbl_a && dbl_b))
      else $error("uncorrectable flag mismatch");
    p_flag_excl_r8: assert (!(err_single_o && err_uncorr_o))
      else $error("single and uncorrectable both set");
    if (!any_a) begin
      p_clean_r2: assert ((rd_data_o == rd_data_i) && !err_single_o)
        else $error("clean word altered");
    end
  end

endmodule

// File: tb/dmr_ham_codec_test.sv
module dmr_ham_codec_test;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  // width 4
  logic [3:0]  wd4 = '0, rd4 = '0, q4;
  logic [3:0]  ra4 = '0, rb4 = '0, wa4, wb4;
  logic        s4, u4;
  // width 8
  logic [7:0]  wd8 = '0, rd8 = '0, q8;
  logic [4:0]  ra8 = '0, rb8 = '0, wa8, wb8;
  logic        s8, u8;
  // width 11
  logic [10:0] wd11 = '0, rd11 = '0, q11;
  logic [4:0]  ra11 = '0, rb11 = '0, wa11, wb11;
  logic        s11, u11;

  dmr_ham_codec #(.DATA_W(8)) uut (
    .wr_data_i(wd8), .wr_chk_a_o(wa8), .wr_chk_b_o(wb8),
    .rd_data_i(rd8), .rd_chk_a_i(ra8), .rd_chk_b_i(rb8),
    .rd_data_o(q8), .err_single_o(s8), .err_uncorr_o(u8));

  dmr_ham_codec #(.DATA_W(4)) uut_w4 (
    .wr_data_i(wd4), .wr_chk_a_o(wa4), .wr_chk_b_o(wb4),
    .rd_data_i(rd4), .rd_chk_a_i(ra4), .rd_chk_b_i(rb4),
    .rd_data_o(q4), .err_single_o(s4), .err_uncorr_o(u4));

  dmr_ham_codec #(.DATA_W(11)) uut_w11 (
    .wr_data_i(wd11), .wr_chk_a_o(wa11), .wr_chk_b_o(wb11),
    .rd_data_i(rd11), .rd_chk_a_i(ra11), .rd_chk_b_i(rb11),
    .rd_data_o(q11), .err_single_o(s11), .err_uncorr_o(u11));

  function automatic int hw_of(input int dw);
    int r;
    r = 1;
    while ((1 << r) < dw + r + 1) r++;
    return r;
  endfunction

  // behavioural reference: walk codeword positions, accumulate check bits
  function automatic logic [5:0] ref_chk(input int dw, input logic [15:0] d);
    logic [5:0] c;
    int h, k;
    logic par;
    h = hw_of(dw);
    c = '0;
    k = 0;
    par = 1'b0;
    for (int p = 1; p <= dw + h; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (d[k]) begin
          par = ~par;
          for (int j = 0; j < h; j++) if (p[j]) c[j] = ~c[j];
        end
        k++;
      end
    end
    for (int j = 0; j < h; j++) par = par ^ c[j];
    c[h] = par;
    return c;
  endfunction

  task automatic drive_wr(input int w, input logic [15:0] d);
    @(negedge clk);
    case (w)
      4: wd4 = d[3:0];
      8: wd8 = d[7:0];
      default: wd11 = d[10:0];
    endcase
    #5;
  endtask

  task automatic drive_rd(input int w, input logic [15:0] d, input logic [5:0] a, input logic [5:0] b);
    @(negedge clk);
    case (w)
      4: begin rd4 = d[3:0]; ra4 = a[3:0]; rb4 = b[3:0]; end
      8: begin rd8 = d[7:0]; ra8 = a[4:0]; rb8 = b[4:0]; end
      default: begin rd11 = d[10:0]; ra11 = a[4:0]; rb11 = b[4:0]; end
    endcase
    #5;
  endtask

  task automatic get_out(input int w, output logic [15:0] q, output logic s, output logic u,
                         output logic [5:0] ea, output logic [5:0] eb);
    q = '0; ea = '0; eb = '0;
    case (w)
      4: begin q[3:0] = q4; s = s4; u = u4; ea[3:0] = wa4; eb[3:0] = wb4; end
      8: begin q[7:0] = q8; s = s8; u = u8; ea[4:0] = wa8; eb[4:0] = wb8; end
      default: begin q[10:0] = q11; s = s11; u = u11; ea[4:0] = wa11; eb[4:0] = wb11; end
    endcase
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_width(input int w, input int npat);
    int cw, nb;
    logic [15:0] mask, d, dd, q;
    logic [5:0] c, a, b, ea, eb;
    logic s, u;
    cw = hw_of(w) + 1;
    nb = w + 2 * cw;
    mask = 16'((1 << w) - 1);
    for (int pat = 0; pat < npat; pat++) begin
      d = (w == 4) ? 16'(pat) : (16'(pat * 173 + 91) & mask);
      c = ref_chk(w, d);
      drive_wr(w, d);
      get_out(w, q, s, u, ea, eb);
      check("R1/R9 copy A", 32'(ea), 32'(c));
      check("R1/R9 copy B", 32'(eb), 32'(c));
      for (int i = 0; i <= nb; i++) begin
        for (int j = i; j <= nb; j++) begin
          int ca, cb, nd, na, nbf;
          string tag;
          if (i == j && i < nb) continue;
          if (i < w && j < w) continue;
          dd = d; a = c; b = c;
          nd = 0; na = 0; nbf = 0;
          for (int t = 0; t < 2; t++) begin
            int k;
            k = (t == 0) ? i : j;
            if (k < nb) begin
              if (k < w) begin dd[k] = ~dd[k]; nd++; end
              else if (k < w + cw) begin a[k - w] = ~a[k - w]; na++; end
              else begin b[k - w - cw] = ~b[k - w - cw]; nbf++; end
            end
          end
          ca = nd + na;
          cb = nd + nbf;
          if (nd + na + nbf == 0) tag = "R2";
          else if (nd + na + nbf == 1) tag = "R3";
          else if (nd == 1 && na == 1) tag = "R4";
          else if (na == 1 && nbf == 1) tag = "R5";
          else tag = "R6";
          drive_rd(w, dd, a, b);
          get_out(w, q, s, u, ea, eb);
          check({tag, " data"}, 32'(q), 32'(d));
          check("R7 no uncorrectable", 32'(u), 32'd0);
          check("R8 single flag", 32'(s), (ca <= 1) ? 32'(ca == 1) : 32'(cb == 1));
        end
      end
      // data + one flip in each copy: both paths double
      for (int k = 0; k < w; k += 3) begin
        dd = d; a = c; b = c;
        dd[k] = ~dd[k];
        a[k % cw] = ~a[k % cw];
        b[(k + 1) % cw] = ~b[(k + 1) % cw];
        drive_rd(w, dd, a, b);
        get_out(w, q, s, u, ea, eb);
        check("R7 uncorrectable", 32'(u), 32'd1);
        check("R8 single low when uncorrectable", 32'(s), 32'd0);
      end
    end
  endtask

  initial begin
    logic [15:0] q;
    logic [5:0] ea, eb;
    logic s, u;
    #15;
    // all-zero word: encodes to zero and reads clean
    get_out(8, q, s, u, ea, eb);
    check("R1 zero encode", 32'(ea), 32'd0);
    check("R2 zero read", 32'(q), 32'd0);
    check("R2 zero single", 32'(s), 32'd0);
    check("R2 zero uncorr", 32'(u), 32'd0);
    run_width(4, 16);
    run_width(8, 64);
    run_width(11, 64);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles, expected completion", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule